// File: doc/BRIEF.md
# Programmable Clock-Enable Divider with Update Handshake

This block turns a free-running clock into a periodic one-cycle enable pulse whose spacing is set by a small code held in a control register. Software writes the code through a simple write port. Each code stands for a division ratio of 1, 2, 4 or 8. A write takes effect only if it carries a write-enable bit that sits 16 bit positions above the code field. This lets several dividers share one register word without disturbing each other.

A ratio change never cuts a period short. The new ratio is stored as pending, and the divider finishes the period it is running under the old ratio before switching. From the accepted write until the switch, a busy bit in a status word reads 1. Software waits for that bit to read 0 before it writes again, and waits for it to read 0 after the write before it relies on the new rate. A write that arrives while the bit is set is dropped.

Top module: `dyn_clkdiv`

## Requirements
- R1: After reset the code field reads 0, the busy bit reads 0, and the ratio is 1, so `tick_o` is high on every cycle.
- R2: A write on `wr_en_i` is accepted only when bit SHIFT+16 of `wr_data_i` is 1. If that bit is 0, the field, the busy bit and the tick spacing are all unchanged.
- R3: The code occupies bits SHIFT+WIDTH-1 down to SHIFT of both `wr_data_i` and `ctrl_rdata_o`, with SHIFT=4 and WIDTH=3 by default. SHIFT+WIDTH may not exceed 16. Every other bit of `ctrl_rdata_o` reads 0, and an accepted write shows its code on the next cycle.
- R4: The busy bit is bit MON_BIT of `status_o` (MON_BIT=5 by default). It is 1 in the cycle after an accepted write. Every other status bit reads 0.
- R5: A write made while the busy bit is 1 is ignored, even if its write-enable bit is set.
- R6: Code k selects ratio 2^k for k = 0 to 3. Every other code selects ratio 1.
- R7: At ratio N, `tick_o` is high for exactly one cycle out of every N (every cycle when N = 1).
- R8: A pending ratio takes effect only at the end of the current period. The tick that closes the old period comes exactly old-N cycles after the tick before it, and the busy bit falls in that same cycle.
- R9: The busy bit stays high for at least 1 and at most old-N cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock being divided |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | DATA_W | Write word: code field plus write-enable bit at SHIFT+16 |
| ctrl_rdata_o | output | DATA_W | Readback of the code field in place |
| status_o | output | STAT_W | Status word; bit MON_BIT is the busy bit |
| tick_o | output | 1 | One-cycle clock-enable pulse every N cycles |

## Verification
The bench steps through every ordered pair of the eight codes. Reserved codes therefore meet real ratios on both sides of a switch. A design that decoded them wrongly would tick at a spacing other than 1.

At each switch the bench measures the gap that closes the old period. A design that switched ratio in the middle of a period would produce a short gap there. It also times the busy bit: a design that dropped busy early or late would fail that check.

Writes with the enable bit cleared but every other bit set must change nothing. A second write landing inside the busy window must leave the first code in force. A design that accepted either would show a different field readback or a different tick spacing.

// File: rtl/dyndiv_pkg.sv
package dyndiv_pkg;
  // Division ratio for a code: powers of two up to 2**log2_max, else 1.
  function automatic int unsigned code_ratio(input int unsigned code,
                                             input int unsigned log2_max);
    if (code <= log2_max) return 32'd1 << code;
    return 32'd1;
  endfunction
endpackage

// File: rtl/dyndiv_ctrl.sv
module dyndiv_ctrl #(
  parameter int SHIFT  = 4,
  parameter int WIDTH  = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              apply_i,
  output logic [WIDTH-1:0]  field_o,
  output logic              busy_o
);
  localparam int EN_POS = SHIFT + 16;

  logic accept;
  assign accept = wr_en_i && wr_data_i[EN_POS] && !busy_o;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      field_o <= '0;
      busy_o  <= 1'b0;
    end else if (accept) begin
      field_o <= wr_data_i[SHIFT +: WIDTH];
      busy_o  <= 1'b1;
    end else if (apply_i) begin
      busy_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/dyndiv_lut.sv
module dyndiv_lut
  import dyndiv_pkg::*;
#(
  parameter int WIDTH    = 3,
  parameter int LOG2_MAX = 3,
  parameter int CNT_W    = 3
) (
  input  logic [WIDTH-1:0] code_i,
  output logic [CNT_W-1:0] term_o
);
  localparam int CODES = 1 << WIDTH;

  logic [CNT_W-1:0] table_q [CODES];

  for (genvar g = 0; g < CODES; g++) begin : g_entry
    localparam int unsigned RT = code_ratio(g, LOG2_MAX);
    assign table_q[g] = CNT_W'(RT - 1);
  end

  assign term_o = table_q[code_i];
endmodule

// File: rtl/dyndiv_cnt.sv
module dyndiv_cnt #(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             pending_i,
  input  logic [CNT_W-1:0] next_term_i,
  output logic             apply_o,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] term_q;
  logic             at_end;

  assign at_end  = (cnt_q == term_q);
  assign apply_o = at_end && pending_i;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q  <= '0;
      term_q <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= at_end;
      if (at_end) begin
        cnt_q <= '0;
        if (pending_i) term_q <= next_term_i;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dyn_clkdiv.sv
module dyn_clkdiv #(
  parameter int SHIFT    = 4,
  parameter int WIDTH    = 3,
  parameter int LOG2_MAX = 3,
  parameter int DATA_W   = 32,
  parameter int STAT_W   = 32,
  parameter int MON_BIT  = 5
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] ctrl_rdata_o,
  output logic [STAT_W-1:0] status_o,
  output logic              tick_o
);
  localparam int CNT_W = (LOG2_MAX > 0) ? LOG2_MAX : 1;

  if (SHIFT + WIDTH > 16) begin : g_bad_field
    $error("code field must lie below bit 16");
  end

  logic [WIDTH-1:0] field;
  logic             busy;
  logic             apply;
  logic [CNT_W-1:0] next_term;

  dyndiv_ctrl #(.SHIFT(SHIFT), .WIDTH(WIDTH), .DATA_W(DATA_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .apply_i   (apply),
    .field_o   (field),
    .busy_o    (busy)
  );

  dyndiv_lut #(.WIDTH(WIDTH), .LOG2_MAX(LOG2_MAX), .CNT_W(CNT_W)) u_lut (
    .code_i (field),
    .term_o (next_term)
  );

  dyndiv_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .pending_i   (busy),
    .next_term_i (next_term),
    .apply_o     (apply),
    .tick_o      (tick_o)
  );

  always_comb begin
    ctrl_rdata_o = '0;
    ctrl_rdata_o[SHIFT +: WIDTH] = field;
    status_o = '0;
    status_o[MON_BIT] = busy;
  end
endmodule

// File: rtl/dyn_clkdiv_chk.sv
module dyn_clkdiv_chk #(
  parameter int SHIFT    = 4,
  parameter int LOG2_MAX = 3,
  parameter int DATA_W   = 32,
  parameter int STAT_W   = 32,
  parameter int MON_BIT  = 5
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [DATA_W-1:0] ctrl_rdata_o,
  input logic [STAT_W-1:0] status_o,
  input logic              tick_o
);
  localparam int MAXR = 1 << LOG2_MAX;

  logic busy;
  logic [7:0] busy_run;
  assign busy = status_o[MON_BIT];

  always_ff @(posedge clk_i) begin
    if (rst_i) busy_run <= '0;
    else if (busy) busy_run <= busy_run + 1'b1;
    else busy_run <= '0;
  end

  // R4
  accept_sets_busy_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_en_i && wr_data_i[SHIFT+16] && !busy) |=> busy);

  // R2
  no_enable_no_change_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_en_i && !wr_data_i[SHIFT+16] && !busy) |=> ($stable(ctrl_rdata_o) && !busy));

  // R5
  busy_write_dropped_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_en_i && busy) |=> $stable(ctrl_rdata_o));

  // R8
  switch_on_tick_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(busy) |-> tick_o);

  // R9
  busy_bounded_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    busy_run <= 8'(MAXR));
endmodule

bind dyn_clkdiv dyn_clkdiv_chk #(
  .SHIFT(SHIFT), .LOG2_MAX(LOG2_MAX), .DATA_W(DATA_W),
  .STAT_W(STAT_W), .MON_BIT(MON_BIT)
) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
  .ctrl_rdata_o(ctrl_rdata_o), .status_o(status_o), .tick_o(tick_o)
);

// File: tb/dyn_clkdiv_test.sv
`timescale 1ns/1ps
module dyn_clkdiv_test;
  localparam int SHIFT = 4, WIDTH = 3, LOG2_MAX = 3;
  localparam int DATA_W = 32, STAT_W = 32, MON_BIT = 5;

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [DATA_W-1:0] rdata;
  logic [STAT_W-1:0] status;
  logic tick;

  int checks = 0, errors = 0;
  int cyc = 0, last_tick_cyc = 0, last_gap = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dyn_clkdiv #(.SHIFT(SHIFT), .WIDTH(WIDTH), .LOG2_MAX(LOG2_MAX),
               .DATA_W(DATA_W), .STAT_W(STAT_W), .MON_BIT(MON_BIT)) uut (
    .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .ctrl_rdata_o(rdata), .status_o(status), .tick_o(tick)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (tick) begin
      last_gap      <= cyc - last_tick_cyc;
      last_tick_cyc <= cyc;
    end
  end

  function automatic int exp_ratio(input int code);
    return (code <= LOG2_MAX) ? (1 << code) : 1;
  endfunction

  function automatic logic [DATA_W-1:0] mk(input int code, input bit en, input bit noise);
    logic [DATA_W-1:0] d;
    d = noise ? '1 : '0;
    d[SHIFT +: WIDTH] = WIDTH'(code);
    d[SHIFT+16] = en;
    return d;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic wait_idle();
    while (status[MON_BIT]) step();
  endtask

  // R7 / R6: count ticks over four periods and measure the spacing
  task automatic check_period(input int n, input string req);
    int hits = 0;
    while (!tick) step();
    for (int i = 0; i < 4*n; i++) begin
      step();
      if (tick) hits++;
    end
    chk(hits == 4, req, hits, 4);
    chk(last_gap == n, req, last_gap, n);
  endtask

  task automatic write_code(input int code, input int old_code, input bit noise);
    int n = 0;
    int old_n = exp_ratio(old_code);
    wait_idle();
    step();
    wr_en = 1'b1; wr_data = mk(code, 1'b1, noise);
    step();
    wr_en = 1'b0; wr_data = '0;
    // R4: busy visible right after the accepted write
    chk(status[MON_BIT] == 1'b1, "R4", status[MON_BIT], 1);
    chk((status & ~(STAT_W'(1) << MON_BIT)) == '0, "R4", status, 0);
    // R3: field readback in place, other bits zero
    chk(rdata == (DATA_W'(code) << SHIFT), "R3", rdata, DATA_W'(code) << SHIFT);
    n = 1;
    while (status[MON_BIT]) begin step(); if (status[MON_BIT]) n++; end
    // R9
    chk(n <= old_n, "R9", n, old_n);
    // R8: busy falls with the tick closing a full old period
    chk(tick == 1'b1, "R8", tick, 1);
    chk(last_gap == old_n, "R8", last_gap, old_n);
    check_period(exp_ratio(code), "R6");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int cur;
    repeat (3) @(posedge clk);
    step();
    rst = 1'b0;
    // R1
    chk(rdata == '0, "R1", rdata, 0);
    chk(status == '0, "R1", status, 0);
    step(); step();
    chk(tick == 1'b1, "R1", tick, 1);
    check_period(1, "R7");

    // Near-exhaustive ordered pairs of codes
    cur = 0;
    for (int a = 0; a < (1 << WIDTH); a++) begin
      for (int b = 0; b < (1 << WIDTH); b++) begin
        write_code(a, cur, (a + b) % 2 == 1); cur = a;
        write_code(b, cur, 1'b0); cur = b;
      end
    end

    // R2: enable bit clear, all other bits set
    write_code(2, cur, 1'b0); cur = 2;
    step();
    wr_en = 1'b1; wr_data = mk(3, 1'b0, 1'b1);
    step();
    wr_en = 1'b0; wr_data = '0;
    chk(status[MON_BIT] == 1'b0, "R2", status[MON_BIT], 0);
    chk(rdata == (DATA_W'(2) << SHIFT), "R2", rdata, DATA_W'(2) << SHIFT);
    check_period(4, "R2");

    // R5: second write inside the busy window is dropped
    write_code(3, cur, 1'b0); cur = 3;
    step();
    wr_en = 1'b1; wr_data = mk(1, 1'b1, 1'b0);
    step();
    wr_data = mk(2, 1'b1, 1'b1);
    chk(status[MON_BIT] == 1'b1, "R5", status[MON_BIT], 1);
    step();
    wr_en = 1'b0; wr_data = '0;
    chk(rdata == (DATA_W'(1) << SHIFT), "R5", rdata, DATA_W'(1) << SHIFT);
    wait_idle();
    check_period(2, "R5");
    chk(rdata == (DATA_W'(1) << SHIFT), "R5", rdata, DATA_W'(1) << SHIFT);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule